// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector

This block watches a received serial line that has already been decoded to NRZ data and arrives one bit per strobe. It raises a loss-of-signal level when the line goes quiet, meaning a long unbroken run of zero bits, and drops it again only once the line shows a sustained stretch of healthy activity. The two criteria differ on purpose. Raising the level takes a long run of zeros. Dropping it takes a full window of bits in which no four zeros appear in a row.

The level output drives a status register bit. A one-cycle change pulse fires on every rise and every fall of the level, so interrupt logic can latch a change flag without edge-detecting the level itself. Cycles without a strobe are idle. They leave every counter and the level exactly as they were.

Top module: `los_detector`

## Requirements
- R1: Once DECLARE_ZEROS (default 32) consecutive valid bits equal to 0 have been received while the level is low, `los_o` reads 1 on the clock edge that samples the last of those zeros.
- R2: A valid 1 bit while the level is low restarts the zero run, so DECLARE_ZEROS-1 zeros, or a longer stream of zeros broken by a 1 before the limit, leave `los_o` at 0.
- R3: While the level is high, `los_o` returns to 0 on the edge that samples the CLEAR_WINDOW-th (default 32) valid bit of a window that contains no CLEAR_RUN (default 4) consecutive zeros.
- R4: While the level is high, the CLEAR_RUN-th consecutive zero restarts both the window and the zero run. This holds even when that zero would otherwise be the last bit of the window, in which case the level stays 1.
- R5: `los_change_o` is 1 for exactly one clock cycle on each rise and each fall of `los_o`, in the same cycle that `los_o` shows its new value. It is 0 in every other cycle.
- R6: Cycles with `bit_valid_i` = 0 change neither the level nor any count. A zero run spread across idle cycles still counts as one run.
- R7: Asynchronous reset (`rst_ni` = 0) drives `los_o` and `los_change_o` to 0 and clears all counts, so a zero run in progress before reset does not carry over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Strobe qualifying `bit_data_i` in this cycle |
| bit_data_i | input | 1 | Received NRZ data bit |
| los_o | output | 1 | Current loss-of-signal level |
| los_change_o | output | 1 | One-cycle pulse on every change of `los_o` |

## Verification
The two functions that can land on the same bit are completion of the clearing window and detection of the fourth consecutive zero. The bench provokes this by entering the loss state, sending 28 ones and then four zeros, so that the fourth zero is also the 32nd bit of the window. The run restart must win: `los_o` has to stay 1 with no change pulse. The bench then checks that clearing still needs a complete fresh window after that bit. A second case places the restart in the middle of a window. Exactly 31 further bits must then be too few to clear, and the next bit must clear.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    LOS_IDLE = 1'b0,
    LOS_LOST = 1'b1
  } los_state_e;
endpackage

// File: rtl/los_sat_counter.sv
module los_sat_counter #(
  parameter int unsigned LIMIT = 32,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/los_ctrl.sv
module los_ctrl
  import los_pkg::*;
#(
  parameter int unsigned DECLARE_ZEROS = 32,
  parameter int unsigned CLEAR_WINDOW  = 32,
  parameter int unsigned CLEAR_RUN     = 4,
  localparam int unsigned RW = $clog2(DECLARE_ZEROS + 1),
  localparam int unsigned WW = $clog2(CLEAR_WINDOW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_valid_i,
  input  logic          bit_data_i,
  input  logic [RW-1:0] run_cnt_i,
  input  logic [WW-1:0] win_cnt_i,
  output logic          run_inc_o,
  output logic          run_clr_o,
  output logic          win_inc_o,
  output logic          win_clr_o,
  output logic          los_o,
  output logic          los_change_o
);
  localparam logic [RW-1:0] DECL_LAST  = RW'(DECLARE_ZEROS - 1);
  localparam logic [RW-1:0] RUN_LAST   = RW'(CLEAR_RUN - 1);
  localparam logic [WW-1:0] WIN_LAST   = WW'(CLEAR_WINDOW - 1);

  los_state_e state_q, state_d;
  logic       chg_q;
  logic       zero_bit, one_bit;
  logic       declare_evt, run_restart, clear_evt;

  assign zero_bit = bit_valid_i && !bit_data_i;
  assign one_bit  = bit_valid_i &&  bit_data_i;

  always_comb begin
    declare_evt = 1'b0;
    run_restart = 1'b0;
    clear_evt   = 1'b0;
    unique case (state_q)
      LOS_IDLE: declare_evt = zero_bit && (run_cnt_i == DECL_LAST);
      LOS_LOST: begin
        // a run of zeros beats window completion on the same bit
        run_restart = zero_bit && (run_cnt_i == RUN_LAST);
        clear_evt   = bit_valid_i && !run_restart && (win_cnt_i == WIN_LAST);
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (declare_evt)    state_d = LOS_LOST;
    else if (clear_evt) state_d = LOS_IDLE;
  end

  assign run_inc_o = zero_bit;
  assign run_clr_o = one_bit || declare_evt || run_restart || clear_evt;
  assign win_inc_o = (state_q == LOS_LOST) && bit_valid_i;
  assign win_clr_o = (state_q != LOS_LOST) || run_restart || clear_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LOS_IDLE;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= declare_evt || clear_evt;
    end
  end

  assign los_o        = (state_q == LOS_LOST);
  assign los_change_o = chg_q;
endmodule

// File: rtl/los_detector.sv
module los_detector #(
  parameter int unsigned DECLARE_ZEROS = 32,
  parameter int unsigned CLEAR_WINDOW  = 32,
  parameter int unsigned CLEAR_RUN     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_data_i,
  output logic los_o,
  output logic los_change_o
);
  localparam int unsigned RW = $clog2(DECLARE_ZEROS + 1);
  localparam int unsigned WW = $clog2(CLEAR_WINDOW + 1);

  logic [RW-1:0] run_cnt;
  logic [WW-1:0] win_cnt;
  logic          run_inc, run_clr, win_inc, win_clr;

  los_sat_counter #(.LIMIT(DECLARE_ZEROS)) u_run_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (run_clr),
    .inc_i  (run_inc),
    .cnt_o  (run_cnt)
  );

  los_sat_counter #(.LIMIT(CLEAR_WINDOW)) u_win_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (win_clr),
    .inc_i  (win_inc),
    .cnt_o  (win_cnt)
  );

  los_ctrl #(
    .DECLARE_ZEROS (DECLARE_ZEROS),
    .CLEAR_WINDOW  (CLEAR_WINDOW),
    .CLEAR_RUN     (CLEAR_RUN)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_valid_i  (bit_valid_i),
    .bit_data_i   (bit_data_i),
    .run_cnt_i    (run_cnt),
    .win_cnt_i    (win_cnt),
    .run_inc_o    (run_inc),
    .run_clr_o    (run_clr),
    .win_inc_o    (win_inc),
    .win_clr_o    (win_clr),
    .los_o        (los_o),
    .los_change_o (los_change_o)
  );
endmodule

// File: rtl/los_detector_chk.sv
module los_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_valid_i,
  input logic bit_data_i,
  input logic los_o,
  input logic los_change_o
);
  AST_CHG_ON_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_o != $past(los_o)) |-> los_change_o); // R5

  AST_NO_SPURIOUS_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_change_o |-> (los_o != $past(los_o))); // R5

  AST_DECL_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> $past(bit_valid_i && !bit_data_i)); // R1

  AST_CLEAR_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(los_o) |-> $past(bit_valid_i)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_valid_i) |-> ($stable(los_o) && !los_change_o)); // R6

  AST_NO_CLEAR_ON_ZERO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(los_o) && $past(bit_valid_i && !bit_data_i) && $past(bit_valid_i && !bit_data_i, 2)
      && $past(bit_valid_i && !bit_data_i, 3) && $past(bit_valid_i && !bit_data_i, 4)
      && $past(los_o, 4)) |-> los_o); // R4
endmodule

bind los_detector los_detector_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_valid_i  (bit_valid_i),
  .bit_data_i   (bit_data_i),
  .los_o        (los_o),
  .los_change_o (los_change_o)
);

// File: tb/tb_los_detector.sv
`timescale 1ns/1ps
module tb_los_detector;
  localparam real CLK_PERIOD = 5.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic data = 1'b0;
  logic los, chg;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  los_detector dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_valid_i  (valid),
    .bit_data_i   (data),
    .los_o        (los),
    .los_change_o (chg)
  );

  typedef struct packed {
    logic [7:0] cnt;
    logic       vld;
    logic [3:0] pat;   // data for bit k of segment is pat[k % 4]
    logic       los;
    logic       chg;
  } seg_t;

  localparam int NSEG = 22;
  localparam seg_t SEGS [NSEG] = '{
    '{8'd31, 1'b1, 4'h0, 1'b0, 1'b0},  // R2 one short
    '{8'd1,  1'b1, 4'hF, 1'b0, 1'b0},  // R2 one restarts run
    '{8'd10, 1'b0, 4'h0, 1'b0, 1'b0},  // R6 idle
    '{8'd31, 1'b1, 4'h0, 1'b0, 1'b0},  // R6 run across idle
    '{8'd5,  1'b0, 4'h0, 1'b0, 1'b0},  // R6
    '{8'd1,  1'b1, 4'h0, 1'b1, 1'b1},  // R1 declare
    '{8'd1,  1'b0, 4'h0, 1'b1, 1'b0},  // R5 pulse one cycle
    '{8'd31, 1'b1, 4'hF, 1'b1, 1'b0},  // R3 window short
    '{8'd1,  1'b1, 4'hF, 1'b0, 1'b1},  // R3 clear
    '{8'd32, 1'b1, 4'h0, 1'b1, 1'b1},  // R1
    '{8'd28, 1'b1, 4'hF, 1'b1, 1'b0},  // R4 setup
    '{8'd4,  1'b1, 4'h0, 1'b1, 1'b0},  // R4 restart wins over clear
    '{8'd31, 1'b1, 4'hF, 1'b1, 1'b0},  // R4 fresh window
    '{8'd1,  1'b1, 4'hF, 1'b0, 1'b1},  // R3
    '{8'd32, 1'b1, 4'h0, 1'b1, 1'b1},  // R1
    '{8'd32, 1'b1, 4'h8, 1'b0, 1'b1},  // R3 runs of three zeros clear
    '{8'd32, 1'b1, 4'h0, 1'b1, 1'b1},  // R1
    '{8'd16, 1'b1, 4'h7, 1'b1, 1'b0},  // R4 setup, ends on a zero
    '{8'd4,  1'b1, 4'h0, 1'b1, 1'b0},  // R4 restart mid window
    '{8'd6,  1'b0, 4'hF, 1'b1, 1'b0},  // R6 idle in window
    '{8'd30, 1'b1, 4'hF, 1'b1, 1'b0},  // R4 window restarted
    '{8'd1,  1'b1, 4'hF, 1'b0, 1'b1}   // R3
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic v, input logic d);
    @(negedge clk);
    valid = v;
    data  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b0;
    #1;
    check("R7 los in reset", los, 1'b0);
    check("R7 chg in reset", chg, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R7 reset los", los, 1'b0);
    check("R7 reset chg", chg, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEGS[s].cnt); k++)
        send(SEGS[s].vld, SEGS[s].pat[k % 4]);
      check($sformatf("R1/R3/R4 seg %0d los", s), los, SEGS[s].los);
      check($sformatf("R5 seg %0d chg", s), chg, SEGS[s].chg);
    end

    // R7: partial run does not survive reset
    for (int k = 0; k < 20; k++) send(1'b1, 1'b0);
    pulse_reset();
    for (int k = 0; k < 12; k++) send(1'b1, 1'b0);
    check("R7 run cleared by reset", los, 1'b0);
    for (int k = 0; k < 19; k++) send(1'b1, 1'b0);
    check("R2 31 zeros after reset", los, 1'b0);
    send(1'b1, 1'b0);
    check("R1 32nd zero declares", los, 1'b1);
    check("R5 pulse with declare", chg, 1'b1);
    send(1'b1, 1'b0);
    check("R5 pulse ends", chg, 1'b0);

    // R7: reset while lost
    pulse_reset();
    send(1'b0, 1'b0);
    check("R7 los after reset", los, 1'b0);
    check("R7 chg after reset", chg, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule